// File: doc/BRIEF.md
# Configurable Timer with Clock-Time Counting

This block is a 32-bit timer. It is programmed through a small register port with single-cycle access. A control register picks one of four clock-enable inputs and a power-of-two prescale. It also sets the count direction, chooses free-running or periodic reload, and selects one of two count formats. The first format is plain binary. The second is a packed clock-time format, hours:minutes:seconds:hundredths, with an hours ceiling of 23 or 255.

Each wrap of the counter is an overflow event. The interrupt comes either from every overflow or from an 8-bit postscaler that counts overflows up to a programmed terminal value. The interrupt stays asserted until software writes the clear register. A capture register records the counter value when a selected line of an 18-line event bus is high.

Top module: `tick_timer`

## Requirements
- R1: Register addresses are 0 control, 1 load, 2 value, 3 capture and 4 clear; other addresses read as zero. After reset, control, load, value and capture all read 0 and `irq` is low.
- R2: Control bits [11:9] select the count source. Codes 0 to 3 take `src_tick[code]`, and codes 4 to 7 supply no ticks.
- R3: Control bits [3:0] set the prescale. Code 4 makes one counter step per 16 selected ticks, code 8 one per 256, and code 15 one per 32768. Every other code makes one step per tick.
- R4: In binary format (bits [5:4] = 00 or 01) the counter adds 1 per step when bit 8 is set and subtracts 1 otherwise. A step from 0xFFFFFFFF up or from 0 down is an overflow and wraps the full range.
- R5: With bit 6 set (periodic), an overflowing step loads the counter from the load register instead of wrapping.
- R6: Writing the load register also writes the counter and restarts the prescale count, as does any control write.
- R7: In clock-time format (bits [5:4] = 1x) the value is hours[31:24], minutes[23:16], seconds[15:8] and hundredths[7:0]. Counting up, hundredths roll over after 99 and seconds and minutes after 59, each carrying into the next field. Hours roll over after 23 (code 10) or 255 (code 11), and that roll-over is the overflow.
- R8: Counting down in clock-time format, a field at 0 borrows and becomes its maximum. A step from all zero gives ceiling:59:59:99 and is an overflow.
- R9: Control bits [31:24] are written as the postscaler terminal count, and a written 0 acts as 1. With bit 23 set, each overflow advances the count that reads back in [31:24]. When the count reaches the terminal value, the count returns to 0 and flag bit [19] sets. With bit 23 clear, the count and the flag do not move.
- R10: Control bit 18 selects the interrupt cause. When set, `irq` rises on a postscaler match. When clear, `irq` rises on every overflow.
- R11: `irq` stays high until the clear register is written. That write also zeroes the postscaler count and the flag. A new interrupt cause in the same cycle as the clear wins.
- R12: When bit 17 is set and `evt[n]` is high, with n from bits [16:12] and n at most 17, the capture register takes the counter value from before that clock edge. In all other cases it holds.
- R13: With bit 7 clear the counter does not move on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from `addr` |
| src_tick | input | 4 | Clock-enable pulses of the four count sources |
| evt | input | 18 | Event lines for capture |
| irq | output | 1 | Sticky interrupt |

## Verification
`rd_data` is combinational. The bench sets `addr` shortly after a rising edge and compares one nanosecond later, before any further edge. Each write, tick or event takes effect at the next rising edge. This includes the counter, the postscaler, the flag, the capture and `irq`, so their new values are sampled 1 ns after that edge. Inputs change only on falling edges.

A reference model in the bench advances once per driven cycle and is compared every cycle. Directed steps check the wrap points, prescale counts and postscaler matches against constants.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int EVT_N = 18,
  parameter int SRC_N = 4,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [SRC_N-1:0] src_tick,
  input  logic [EVT_N-1:0] evt,
  output logic             irq
);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_LOAD = AW'(1);
  localparam logic [AW-1:0] A_VAL = AW'(2);
  localparam logic [AW-1:0] A_CAP = AW'(3);
  localparam logic [AW-1:0] A_CLR = AW'(4);

  logic [7:0]  ps_term, ps_cnt;
  logic        ps_en, ps_flag, irq_src, cap_en, up, en, per;
  logic [4:0]  evt_sel;
  logic [2:0]  clk_sel;
  logic [1:0]  fmt;
  logic [3:0]  pre;
  logic [31:0] load_q, cnt_q, cap_q, nxt;
  logic [14:0] pre_cnt, pre_lim;
  logic        irq_q, sel_tick, cap_hit, step, wrap, ov, ps_hit, irq_set;
  logic [7:0]  ceil;
  logic [8:0]  t_h, t_s, t_m, t_r;
  logic        cnt_ok;
  logic        unused_rsv;

  wire we_ctl  = wr_en && addr == A_CTL;
  wire we_load = wr_en && addr == A_LOAD;
  wire we_clr  = wr_en && addr == A_CLR;

  assign unused_rsv = ^wr_data[22:19];
  assign ceil = fmt[0] ? 8'd255 : 8'd23;
  assign irq  = irq_q;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < SRC_N; i++)
      if (int'(clk_sel) == i) sel_tick = src_tick[i];
  end

  always_comb begin
    cap_hit = 1'b0;
    for (int i = 0; i < EVT_N; i++)
      if (int'(evt_sel) == i) cap_hit = cap_en && evt[i];
  end

  always_comb begin
    case (pre)
      4'd4:    pre_lim = 15'd15;
      4'd8:    pre_lim = 15'd255;
      4'd15:   pre_lim = 15'd32767;
      default: pre_lim = 15'd0;
    endcase
  end

  assign step = en && sel_tick && pre_cnt == pre_lim;

  function automatic logic [8:0] f_up(input logic [7:0] f, input logic [7:0] mx, input logic c);
    if (!c) return {1'b0, f};
    else if (f >= mx) return 9'h100;
    else return {1'b0, f + 8'd1};
  endfunction

  function automatic logic [8:0] f_dn(input logic [7:0] f, input logic [7:0] mx, input logic b);
    if (!b) return {1'b0, f};
    else if (f == 8'd0) return {1'b1, mx};
    else return {1'b0, f - 8'd1};
  endfunction

  always_comb begin
    t_h = '0; t_s = '0; t_m = '0; t_r = '0;
    nxt = cnt_q;
    wrap = 1'b0;
    if (fmt[1]) begin
      if (up) begin
        t_h = f_up(cnt_q[7:0], 8'd99, 1'b1);
        t_s = f_up(cnt_q[15:8], 8'd59, t_h[8]);
        t_m = f_up(cnt_q[23:16], 8'd59, t_s[8]);
        t_r = f_up(cnt_q[31:24], ceil, t_m[8]);
      end else begin
        t_h = f_dn(cnt_q[7:0], 8'd99, 1'b1);
        t_s = f_dn(cnt_q[15:8], 8'd59, t_h[8]);
        t_m = f_dn(cnt_q[23:16], 8'd59, t_s[8]);
        t_r = f_dn(cnt_q[31:24], ceil, t_m[8]);
      end
      nxt  = {t_r[7:0], t_m[7:0], t_s[7:0], t_h[7:0]};
      wrap = t_r[8];
    end else if (up) begin
      {wrap, nxt} = {1'b0, cnt_q} + 33'd1;
    end else begin
      nxt  = cnt_q - 32'd1;
      wrap = cnt_q == 32'd0;
    end
  end

  assign ov      = step && wrap;
  assign ps_hit  = ov && ps_en && !we_ctl && ({1'b0, ps_cnt} + 9'd1 == {1'b0, ps_term});
  assign irq_set = irq_src ? ps_hit : ov;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_term <= 8'd1; ps_en <= 1'b0; irq_src <= 1'b0; cap_en <= 1'b0;
      evt_sel <= '0; clk_sel <= '0; up <= 1'b0; en <= 1'b0; per <= 1'b0;
      fmt <= '0; pre <= '0;
    end else if (we_ctl) begin
      ps_term <= (wr_data[31:24] == 8'd0) ? 8'd1 : wr_data[31:24];
      ps_en   <= wr_data[23];
      irq_src <= wr_data[18];
      cap_en  <= wr_data[17];
      evt_sel <= wr_data[16:12];
      clk_sel <= wr_data[11:9];
      up      <= wr_data[8];
      en      <= wr_data[7];
      per     <= wr_data[6];
      fmt     <= wr_data[5:4];
      pre     <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pre_cnt <= '0;
    else if (we_ctl || we_load || !en) pre_cnt <= '0;
    else if (sel_tick) pre_cnt <= step ? 15'd0 : pre_cnt + 15'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else if (we_load) begin
      load_q <= wr_data;
      cnt_q  <= wr_data;
    end else if (step) begin
      cnt_q <= (wrap && per) ? load_q : nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_cnt  <= '0;
      ps_flag <= 1'b0;
      irq_q   <= 1'b0;
      cap_q   <= '0;
    end else begin
      if (we_ctl || we_clr || ps_hit) ps_cnt <= '0;
      else if (ov && ps_en) ps_cnt <= ps_cnt + 8'd1;
      if (ps_hit) ps_flag <= 1'b1;
      else if (we_clr) ps_flag <= 1'b0;
      if (irq_set) irq_q <= 1'b1;
      else if (we_clr) irq_q <= 1'b0;
      if (cap_hit) cap_q <= cnt_q;
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rd_data = {ps_cnt, ps_en, 3'b000, ps_flag, irq_src, cap_en, evt_sel,
                          clk_sel, up, en, per, fmt, pre};
      A_LOAD:  rd_data = load_q;
      A_VAL:   rd_data = cnt_q;
      A_CAP:   rd_data = cap_q;
      default: rd_data = '0;
    endcase
  end

  assign cnt_ok = cnt_q[7:0] <= 8'd99 && cnt_q[15:8] <= 8'd59 &&
                  cnt_q[23:16] <= 8'd59 && cnt_q[31:24] <= ceil;

  AST_TERM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ps_term != 8'd0) else $error("terminal count is zero"); // R9
  AST_FLAG_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_flag) |-> $past(ps_en)) else $error("flag set while disabled"); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !we_clr) |=> irq_q) else $error("irq dropped without clear"); // R11
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (we_clr && !irq_set) |=> !irq_q) else $error("irq survived clear"); // R11
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hit |=> $stable(cap_q)) else $error("capture moved without event"); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !we_load) |=> $stable(cnt_q)) else $error("disabled counter moved"); // R13
  AST_TIME_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fmt[1] && !per && cnt_ok && !we_load && !we_ctl) |=> cnt_ok)
    else $error("time field out of range"); // R7
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0] src_tick = '0;
  logic [17:0] evt = '0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tick_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
                 .rd_data(rd_data), .src_tick(src_tick), .evt(evt), .irq(irq));

  logic [7:0] m_term, m_pscnt;
  logic m_psen, m_flag, m_src, m_capen, m_up, m_en, m_per, m_irq;
  logic [4:0] m_evs;
  logic [2:0] m_cks;
  logic [1:0] m_fmt;
  logic [3:0] m_pre;
  logic [31:0] m_load, m_cnt, m_cap;
  int m_pc;

  function automatic logic [31:0] m_ctl();
    return {m_pscnt, m_psen, 3'b000, m_flag, m_src, m_capen, m_evs, m_cks,
            m_up, m_en, m_per, m_fmt, m_pre};
  endfunction

  function automatic logic [8:0] fu(input logic [7:0] f, input logic [7:0] mx, input logic c);
    if (!c) return {1'b0, f};
    if (f >= mx) return 9'h100;
    return {1'b0, f + 8'd1};
  endfunction

  function automatic logic [8:0] fd(input logic [7:0] f, input logic [7:0] mx, input logic c);
    if (!c) return {1'b0, f};
    if (f == 8'd0) return {1'b1, mx};
    return {1'b0, f - 8'd1};
  endfunction

  function automatic logic [32:0] m_next(input logic [31:0] v, input logic u, input logic [1:0] fm);
    logic [8:0] a, b, c, d;
    logic [7:0] top;
    top = fm[0] ? 8'd255 : 8'd23;
    if (!fm[1]) return u ? {(v == 32'hFFFFFFFF), v + 32'd1} : {(v == 32'd0), v - 32'd1};
    if (u) begin
      a = fu(v[7:0], 8'd99, 1'b1); b = fu(v[15:8], 8'd59, a[8]);
      c = fu(v[23:16], 8'd59, b[8]); d = fu(v[31:24], top, c[8]);
    end else begin
      a = fd(v[7:0], 8'd99, 1'b1); b = fd(v[15:8], 8'd59, a[8]);
      c = fd(v[23:16], 8'd59, b[8]); d = fd(v[31:24], top, c[8]);
    end
    return {d[8], d[7:0], c[7:0], b[7:0], a[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mstep(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic [3:0] tk, input logic [17:0] ev);
    logic wc, wl, wk, sel, step, ov, hit, set;
    logic [32:0] r;
    int lim;
    wc = w && a == 3'd0; wl = w && a == 3'd1; wk = w && a == 3'd4;
    sel = (m_cks < 3'd4) ? tk[m_cks[1:0]] : 1'b0;
    lim = (m_pre == 4'd4) ? 15 : (m_pre == 4'd8) ? 255 : (m_pre == 4'd15) ? 32767 : 0;
    step = m_en && sel && m_pc == lim;
    r = m_next(m_cnt, m_up, m_fmt);
    ov = step && r[32];
    hit = ov && m_psen && !wc && ({1'b0, m_pscnt} + 9'd1 == {1'b0, m_term});
    set = m_src ? hit : ov;
    if (m_capen && m_evs < 5'd18 && ev[m_evs]) m_cap = m_cnt;
    if (wc || wl || !m_en) m_pc = 0;
    else if (sel) m_pc = step ? 0 : m_pc + 1;
    if (wl) m_cnt = d;
    else if (step) m_cnt = (r[32] && m_per) ? m_load : r[31:0];
    if (wl) m_load = d;
    if (wc || wk || hit) m_pscnt = 0;
    else if (ov && m_psen) m_pscnt = m_pscnt + 8'd1;
    if (hit) m_flag = 1'b1; else if (wk) m_flag = 1'b0;
    if (set) m_irq = 1'b1; else if (wk) m_irq = 1'b0;
    if (wc) begin
      m_term = (d[31:24] == 8'd0) ? 8'd1 : d[31:24];
      m_psen = d[23]; m_src = d[18]; m_capen = d[17]; m_evs = d[16:12];
      m_cks = d[11:9]; m_up = d[8]; m_en = d[7]; m_per = d[6];
      m_fmt = d[5:4]; m_pre = d[3:0];
    end
  endtask

  task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d,
                     input logic [3:0] tk, input logic [17:0] ev);
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; src_tick = tk; evt = ev;
    mstep(w, a, d, tk, ev);
    @(posedge clk); #1;
    wr_en = 1'b0; src_tick = '0; evt = '0;
    chk("R11 irq vs model", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 4'd0, 18'd0);
  endtask

  task automatic tick(input int n, input logic [3:0] mask);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, mask, 18'd0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic irqis(input logic e, input string tag);
    chk(tag, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_term = 8'd1; m_pscnt = '0; m_psen = 0; m_flag = 0; m_src = 0; m_capen = 0;
    m_up = 0; m_en = 0; m_per = 0; m_irq = 0; m_evs = '0; m_cks = '0; m_fmt = '0;
    m_pre = '0; m_load = '0; m_cnt = '0; m_cap = '0; m_pc = 0;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    rd(3'd0, 32'h0, "R1 reset control"); rd(3'd1, 32'h0, "R1 reset load");
    rd(3'd2, 32'h0, "R1 reset value"); rd(3'd3, 32'h0, "R1 reset capture");
    rd(3'd6, 32'h0, "R1 unused address"); irqis(1'b0, "R1 reset irq");

    wr(0, 32'h80); wr(1, 32'h0); tick(1, 4'b0001);
    rd(2, 32'hFFFFFFFF, "R4 down wrap"); irqis(1'b1, "R4 underflow irq");
    wr(4, 0); irqis(1'b0, "R11 clear drops irq");
    wr(0, 32'h180); wr(1, 32'hFFFFFFFE); tick(1, 4'b0001);
    rd(2, 32'hFFFFFFFF, "R4 up count"); irqis(1'b0, "R4 no early irq");
    tick(1, 4'b0001); rd(2, 32'h0, "R4 up wrap"); irqis(1'b1, "R4 overflow irq");
    wr(4, 0);

    wr(0, 32'hA80); wr(1, 32'd10); tick(3, 4'b1111);
    rd(2, 32'd10, "R2 source code 5 idle");
    wr(0, 32'h480); tick(1, 4'b0001); rd(2, 32'd10, "R2 wrong source ignored");
    tick(1, 4'b0100); rd(2, 32'd9, "R2 source 2 counts");

    wr(0, 32'h84); wr(1, 32'd100); tick(15, 4'b0001);
    rd(2, 32'd100, "R3 divide 16 not yet"); tick(1, 4'b0001);
    rd(2, 32'd99, "R3 divide 16 step");
    wr(0, 32'h83); tick(1, 4'b0001); rd(2, 32'd98, "R3 other code divides by 1");

    wr(0, 32'h1C0); wr(1, 32'hFFFFFFFE); tick(2, 4'b0001);
    rd(2, 32'hFFFFFFFE, "R5 periodic reload"); irqis(1'b1, "R5 reload irq"); wr(4, 0);

    wr(0, 32'h1A0); wr(1, 32'h173B3B63); tick(1, 4'b0001);
    rd(2, 32'h0, "R7 23h rollover"); irqis(1'b1, "R7 time overflow irq"); wr(4, 0);
    wr(1, 32'h003B3B63); tick(1, 4'b0001); rd(2, 32'h01000000, "R7 carry into hours");
    wr(1, 32'h00003B63); tick(1, 4'b0001); rd(2, 32'h00010000, "R7 carry into minutes");
    wr(0, 32'h1B0); wr(1, 32'h173B3B63); tick(1, 4'b0001);
    rd(2, 32'h18000000, "R7 255h ceiling passes 23"); irqis(1'b0, "R7 no irq at 24h");
    wr(1, 32'hFF3B3B63); tick(1, 4'b0001); rd(2, 32'h0, "R7 255h rollover");
    irqis(1'b1, "R7 255h irq"); wr(4, 0);
    wr(0, 32'h190); wr(1, 32'h63); tick(1, 4'b0001); rd(2, 32'h64, "R7 code 01 is binary");

    wr(0, 32'hA0); wr(1, 32'h0); tick(1, 4'b0001);
    rd(2, 32'h173B3B63, "R8 down borrow 23h"); irqis(1'b1, "R8 underflow irq"); wr(4, 0);
    wr(1, 32'h01000000); tick(1, 4'b0001); rd(2, 32'h003B3B63, "R8 borrow from hours");
    wr(0, 32'hB0); wr(1, 32'h0); tick(1, 4'b0001);
    rd(2, 32'hFF3B3B63, "R8 down borrow 255h"); wr(4, 0);

    wr(0, 32'h00840180); wr(1, 32'hFFFFFFFF); tick(1, 4'b0001);
    rd(0, 32'h008C0180, "R9 zero term acts as one"); irqis(1'b1, "R10 postscaler irq");
    wr(4, 0); rd(0, 32'h00840180, "R11 clear drops flag");
    wr(0, 32'h03840180);
    wr(1, 32'hFFFFFFFF); tick(1, 4'b0001); rd(0, 32'h01840180, "R9 count one");
    irqis(1'b0, "R10 no irq before match");
    wr(1, 32'hFFFFFFFF); tick(1, 4'b0001); rd(0, 32'h02840180, "R9 count two");
    wr(1, 32'hFFFFFFFF); tick(1, 4'b0001); rd(0, 32'h008C0180, "R9 match at three");
    irqis(1'b1, "R10 irq at match"); wr(4, 0);
    wr(0, 32'h03800180); wr(1, 32'hFFFFFFFF); tick(1, 4'b0001);
    irqis(1'b1, "R10 direct source"); rd(0, 32'h01800180, "R9 counts with direct irq");
    wr(4, 0); rd(0, 32'h00800180, "R11 clear zeroes count");
    wr(0, 32'h01040180); wr(1, 32'hFFFFFFFF); tick(1, 4'b0001);
    irqis(1'b0, "R9 disabled postscaler no irq"); rd(0, 32'h00040180, "R9 disabled no flag");

    wr(0, 32'h31080); wr(1, 32'h12345678);
    cyc(0, 0, 0, 4'd0, 18'h8); rd(3, 32'h0, "R12 other line ignored");
    cyc(0, 0, 0, 4'd0, 18'h20000); rd(3, 32'h12345678, "R12 capture line 17");
    wr(0, 32'h34080); wr(1, 32'd5); cyc(0, 0, 0, 4'd0, 18'h3FFFF);
    rd(3, 32'h12345678, "R12 number above 17 ignored");
    wr(0, 32'h11080); cyc(0, 0, 0, 4'd0, 18'h20000);
    rd(3, 32'h12345678, "R12 capture disabled");

    wr(0, 32'h100); wr(1, 32'd7); tick(3, 4'b1111); rd(2, 32'd7, "R13 disabled holds");
    wr(0, 32'h84); wr(1, 32'd50); tick(10, 4'b0001); wr(1, 32'd50); tick(15, 4'b0001);
    rd(2, 32'd50, "R6 load restarts prescale"); tick(1, 4'b0001);
    rd(2, 32'd49, "R6 step after restart");

    wr(0, 32'h80); wr(1, 32'h0); cyc(1, 3'd4, 0, 4'b0001, 18'd0);
    irqis(1'b1, "R11 set beats clear"); wr(4, 0);

    for (int k = 0; k < 4000; k++) begin
      int r;
      if (k % 250 == 0) begin
        logic [3:0] pr;
        logic [31:0] c;
        case ($urandom % 4) 0: pr = 4'd0; 1: pr = 4'd4; 2: pr = 4'd3; default: pr = 4'd8; endcase
        c = {8'($urandom % 4), 1'($urandom), 3'b000, 1'b0, 1'($urandom), 1'($urandom),
             5'($urandom % 20), 3'($urandom % 6), 1'($urandom), 1'($urandom % 8 != 0),
             1'($urandom), 2'($urandom), pr};
        wr(0, c);
      end
      r = $urandom % 100;
      if (r < 2) wr(4, 0);
      else if (r < 5) begin
        logic [31:0] v;
        if (m_fmt[1]) v = ($urandom % 2) ? {8'd23, 8'd59, 8'd59, 8'(90 + $urandom % 10)}
                                         : {24'd0, 8'($urandom % 10)};
        else v = ($urandom % 2) ? 32'hFFFFFFF0 + ($urandom % 16) : 32'($urandom % 16);
        wr(1, v);
      end else
        cyc(0, 0, 0, 4'($urandom), ($urandom % 8 == 0) ? 18'(1 << ($urandom % 18)) : 18'd0);
      rd(2, m_cnt, "R4 R7 R8 value vs model");
      if (k % 8 == 0) begin
        rd(0, m_ctl(), "R9 control vs model");
        rd(3, m_cap, "R12 capture vs model");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule